// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block sits between synchronous logic and an asynchronous static RAM of 128K bytes. A client offers one write at a time on a valid/ready port. When the write is accepted, the sequencer captures the address and the data. It then plays out a write cycle on the memory pins: both chip selects go active, the write strobe is lowered, and the sequencer's own data driver is switched on. The strobes and the driver are released together when the write ends. A one-cycle completion pulse follows.

Every interval is a whole number of clock cycles. Each one is derived from a nanosecond minimum and the clock period (`CLK_NS`), and the parameter `FAST` selects between two speed grades. The memory's output enable is held inactive at all times, so the memory never drives the shared bus while a write is in progress. The derived counts at the defaults (4 ns clock, fast grade) are given in the requirements below.

Top module: `sram_write_seq`

## Requirements
- R1: While reset is held, and after it is released, the memory selects are inactive (`mem_sel_n`=1, `mem_sel`=0), `mem_wr_n`=1, `mem_drv`=0, `done`=0 and `req_ready`=1.
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. Its address and data are captured at that edge, and `req_ready` stays 0 until the cycle completes. Changes on `req_addr` or `req_data` after acceptance have no effect on that write.
- R3: Both selects are active from the acceptance edge until PULSE+1 edges later (13 cycles at the defaults). Throughout that time, `mem_addr` holds the captured address.
- R4: `mem_wr_n` goes low one edge after the selects go active and stays low for PULSE cycles. PULSE is the largest of: the pulse minimum (40/50 ns), the address-valid-to-end minimum (50/60 ns) less one cycle, and the data setup (20/25 ns) plus one cycle. PULSE is 12 at the defaults.
- R5: `mem_drv` rises one edge after `mem_wr_n` falls, and only while both selects are active. It drops at the same edge where `mem_wr_n` rises. While it is high, `mem_dq` carries the captured data.
- R6: `mem_oe_n` is 1 at all times.
- R7: `done` is 1 for exactly the one cycle that follows the edge ending the write.
- R8: Successive accepted writes start at least the cycle-time minimum (55/70 ns, 14 cycles at the defaults) apart. `req_ready` returns to 1 exactly that many edges after acceptance.
- R9: A memory that latches `mem_dq` when `mem_wr_n` rises stores, for every accepted request, that request's data at that request's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_addr | input | 17 | Write address |
| req_data | input | 8 | Write data |
| done | output | 1 | One-cycle pulse when the write has ended |
| mem_addr | output | 17 | Memory address pins |
| mem_dq | output | 8 | Data driven toward the memory |
| mem_drv | output | 1 | Enable for the data bus driver |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low memory output enable, held high |

## Verification
The assertions check, on every cycle, the ordering that protects the bus:
- the write strobe only falls inside the select window;
- the data driver only runs inside the strobe, turns on strictly after the strobe falls, and is off at the edge where the strobe rises;
- the address holds still while the selects are active;
- the completion pulse lasts a single cycle and coincides with the end of the write.

The exact interval lengths, the cycle-time spacing between back-to-back requests, the ignored changes on the request lines, and the final memory contents depend on counted windows and on stimulus. Only the bench's cycle-by-cycle model and its memory image can show these.

// File: rtl/sram_write_seq.sv
module sram_write_seq #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CLK_NS = 4,
  parameter bit FAST   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq,
  output logic              mem_drv,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_wr_n,
  output logic              mem_oe_n
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_WC  = cyc(FAST ? 55 : 70);
  localparam int T_AW  = cyc(FAST ? 50 : 60);
  localparam int T_WP  = cyc(FAST ? 40 : 50);
  localparam int T_DW  = cyc(FAST ? 20 : 25);
  localparam int PULSE = max2(max2(T_WP, T_AW - 1), T_DW + 1);
  localparam int RECOV = max2(1, T_WC - 1 - PULSE);
  localparam int CNT_W = $clog2(max2(PULSE, RECOV) + 1);

  typedef enum logic [1:0] {IDLE, SETUP, PULSE_S, RECOVER} state_t;

  state_t             st, nxt;
  logic [CNT_W-1:0]   cnt;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;
  logic               sel_q, wr_q, drv_q, done_q;

  always_comb begin
    nxt = st;
    case (st)
      IDLE:    if (req_valid) nxt = SETUP;
      SETUP:   nxt = PULSE_S;
      PULSE_S: if (cnt == CNT_W'(PULSE - 1)) nxt = RECOVER;
      RECOVER: if (cnt == CNT_W'(RECOV - 1)) nxt = IDLE;
      default: nxt = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      addr_q <= '0;
      data_q <= '0;
      sel_q  <= 1'b0;
      wr_q   <= 1'b0;
      drv_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st     <= nxt;
      cnt    <= (nxt != st) ? '0 : cnt + 1'b1;
      if (st == IDLE && req_valid) begin
        addr_q <= req_addr;
        data_q <= req_data;
      end
      sel_q  <= (nxt == SETUP) || (nxt == PULSE_S);
      wr_q   <= (nxt == PULSE_S);
      drv_q  <= (st == PULSE_S) && (nxt == PULSE_S);
      done_q <= (st == PULSE_S) && (nxt == RECOVER);
    end
  end

  assign req_ready = (st == IDLE);
  assign done      = done_q;
  assign mem_addr  = addr_q;
  assign mem_dq    = data_q;
  assign mem_drv   = drv_q;
  assign mem_sel_n = ~sel_q;
  assign mem_sel   = sel_q;
  assign mem_wr_n  = ~wr_q;
  assign mem_oe_n  = 1'b1;

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));
  a_r4_strobe_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> (!mem_sel_n && mem_sel));
  a_r5_drive_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_drv |-> (!mem_wr_n && !mem_sel_n && mem_sel));
  a_r5_drive_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_drv) |-> !$past(mem_wr_n));
  a_r5_release_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n) |-> !mem_drv);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(mem_wr_n));

endmodule

// File: tb/sram_write_seq_tb_top.sv
module sram_write_seq_tb_top;
  localparam int PULSE = 12;
  localparam int WCYC  = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic        req_ready, done, mem_drv, mem_sel_n, mem_sel, mem_wr_n, mem_oe_n;
  logic [16:0] mem_addr;
  logic [7:0]  mem_dq;

  always #2 clk = ~clk;

  sram_write_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .done(done),
    .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_drv(mem_drv),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_wr_n(mem_wr_n), .mem_oe_n(mem_oe_n));

  int checks = 0, fails = 0, cycles = 0, writes_seen = 0, writes_exp = 0;
  int tm = -1;
  logic [16:0] m_addr;
  logic [7:0]  m_data;
  logic [7:0]  ram [int];
  logic [7:0]  exp_ram [int];
  logic        p_wr_n = 1'b1, p_drv = 1'b0;
  logic [16:0] p_addr;
  logic [7:0]  p_dq;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) tm <= -1;
    else if (tm < 0) begin
      if (req_valid) begin
        tm <= 0; m_addr <= req_addr; m_data <= req_data;
        exp_ram[int'(req_addr)] = req_data;
        writes_exp++;
      end
    end else tm <= (tm == WCYC - 1) ? -1 : tm + 1;
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    bit e_sel, e_wr, e_drv;
    e_sel = tm >= 0 && tm <= PULSE;
    e_wr  = tm >= 1 && tm <= PULSE;
    e_drv = tm >= 2 && tm <= PULSE;
    if (!rst_n) begin
      chk(mem_sel_n && !mem_sel && mem_wr_n && !mem_drv && !done, "R1 reset outputs",
          {mem_sel_n, mem_sel, mem_wr_n, mem_drv, done}, 5'b10100);
    end else begin
      chk(req_ready == (tm < 0), "R8 ready timing", req_ready, tm < 0);
      chk(mem_sel_n == !e_sel && mem_sel == e_sel, "R3 selects", mem_sel, e_sel);
      chk(mem_wr_n == !e_wr, "R4 write strobe", mem_wr_n, !e_wr);
      chk(mem_drv == e_drv, "R5 data driver", mem_drv, e_drv);
      chk(mem_oe_n == 1'b1, "R6 output enable", mem_oe_n, 1);
      chk(done == (tm == PULSE + 1), "R7 done pulse", done, tm == PULSE + 1);
      if (e_sel) chk(mem_addr == m_addr, "R3 address", mem_addr, m_addr);
      if (e_drv) chk(mem_dq == m_data, "R5 data value", mem_dq, m_data);
      if (!p_wr_n && mem_wr_n) begin
        chk(p_drv, "R9 data driven at write end", p_drv, 1);
        ram[int'(p_addr)] = p_dq;
        writes_seen++;
        chk(p_dq == m_data && p_addr == m_addr, "R2 captured data", p_dq, m_data);
      end
    end
    p_wr_n = mem_wr_n; p_drv = mem_drv; p_addr = mem_addr; p_dq = mem_dq;
  end

  task automatic wr(input logic [16:0] a, input logic [7:0] d, input int junk, input int gap);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d;
    @(negedge clk);
    for (int i = 0; i < junk; i++) begin
      req_addr = a ^ 17'h1_5555; req_data = ~d;
      @(negedge clk);
    end
    req_valid = 1'b0;
    for (int i = 0; i < gap; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    wr(17'h00000, 8'h00, 0, 0);
    wr(17'h1FFFF, 8'hFF, 5, 0);
    wr(17'h0AAAA, 8'hA5, 10, 3);
    wr(17'h15555, 8'h5A, 0, 20);
    for (int i = 0; i < 12; i++) wr(17'(i * 997 + 3), 8'(i * 37 + 1), i % 4, i % 3);
    wr(17'h1FFFF, 8'h3C, 0, 0);
    repeat (WCYC + 4) @(negedge clk);
    chk(writes_seen == writes_exp, "R9 write count", writes_seen, writes_exp);
    foreach (exp_ram[k])
      chk(ram.exists(k) && ram[k] == exp_ram[k], "R9 memory image",
          ram.exists(k) ? ram[k] : 'x, exp_ram[k]);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule